// File: doc/BRIEF.md
# Link Speed Validation Controller

This controller sits on the initiator side of a parallel peripheral link. It picks the transfer rate the link will use before any user traffic runs. A validation begins with a start pulse and the highest rate index the target reports. The controller then runs a write-then-readback test at that rate through a simple transfer engine.

Each test has two halves. First the controller writes a fixed toggling pattern to the target's buffer. It then reads the buffer back, compares every returned word with the pattern and watches the CRC-error input. If the test fails, the rate index drops by one step and the test runs again. If the test passes, that rate is locked and user transfers are enabled. If the test fails even at the slowest rate, the controller raises a link-fail flag and stops.

Every command phase is guarded by a timeout. A target that never acknowledges, or never returns its data, counts as a failed attempt and does not hang the controller.

Top module: `lsv_rate_validator`

## Requirements
- R1: After reset the controller is idle. `busy_o`, `done_o`, `link_fail_o`, `xfer_en_o`, `wr_req_o`, `rd_req_o` and `wr_valid_o` are all low.
- R2: A validation starts only from idle, on `start_i`. `busy_o` is high from the cycle after `start_i` is sampled. The first attempt runs at rate index `max_rate_i`. A `start_i` that arrives while busy has no effect.
- R3: An attempt first holds `wr_req_o` high until `wr_ack_i`. From the next cycle it drives 32 words, one per cycle, with `wr_valid_o` high. Word k carries a single one at bit ((k>>1) mod 16) when k is even, and the bitwise complement of the previous word when k is odd.
- R4: After the write, the controller holds `rd_req_o` high until `rd_ack_i`. It then accepts 32 words on the cycles where `rd_valid_i` is high. `wr_req_o` and `rd_req_o` are never high together.
- R5: An attempt passes only when two things hold. Every read word must equal the corresponding written word, the last word included. `crc_err_i` must stay low on every cycle from the write request to the last read word.
- R6: When an attempt fails at a rate index above 0, `rate_o` drops by exactly one and a new write/read attempt begins. `rate_o` never rises during a validation.
- R7: When an attempt fails at rate index 0, `link_fail_o` goes high and the controller returns to idle. No rate is locked.
- R8: A missing `wr_ack_i`, a missing `rd_ack_i`, or an incomplete read stream fails the attempt after 4096 cycles (`TIMEOUT`) in that phase.
- R9: `done_o` is a one-cycle pulse at the end of each validation. It is raised together with the update of `xfer_en_o` or `link_fail_o` and the drop of `busy_o`.
- R10: `xfer_en_o` is high only after a rate has passed and been locked. It is never high while `busy_o` is high. A new start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a validation (ignored unless idle) |
| max_rate_i | input | 3 | Highest rate index the target supports |
| wr_req_o | output | 1 | Buffer-write command request |
| wr_ack_i | input | 1 | Write command acknowledge |
| wr_valid_o | output | 1 | Write data word valid |
| wr_data_o | output | 16 | Write data word (test pattern) |
| rd_req_o | output | 1 | Buffer-read command request |
| rd_ack_i | input | 1 | Read command acknowledge |
| rd_valid_i | input | 1 | Read data word valid |
| rd_data_i | input | 16 | Read data word |
| crc_err_i | input | 1 | CRC error flagged by the transfer engine |
| rate_o | output | 3 | Rate index under test or locked |
| done_o | output | 1 | One-cycle pulse at the end of a validation |
| link_fail_o | output | 1 | No rate passed |
| busy_o | output | 1 | Validation in progress |
| xfer_en_o | output | 1 | User transfers allowed |

## Verification
The in-RTL assertions check several properties on every cycle:
- the write and read requests never overlap;
- `done_o` never lasts longer than one cycle;
- user transfers are never enabled while busy or alongside a link failure;
- the rate index never rises within a validation;
- the phase timer never runs past its limit.

Other behaviour only the bench's scenarios can show, using a target model that captures writes and echoes them back:
- the exact pattern words;
- the downward sequence of attempted rates;
- detection of a corrupted last word and of a CRC pulse;
- the two timeout paths;
- that a start pulse while busy is ignored;
- the link-fail outcome at index 0.

// File: rtl/lsv_pkg.sv
package lsv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_CMD,
    ST_WR_DATA,
    ST_RD_CMD,
    ST_RD_DATA,
    ST_EVAL
  } lsv_state_e;
endpackage

// File: rtl/lsv_pattern_gen.sv
module lsv_pattern_gen #(
  parameter int DW    = 16,
  parameter int WORDS = 32,
  localparam int IW   = $clog2(WORDS)
) (
  input  logic [IW-1:0] idx_i,
  output logic [DW-1:0] word_o
);
  // walking one on even words, complement on odd words
  always_comb begin
    word_o = '0;
    word_o[(int'(idx_i) >> 1) % DW] = 1'b1;
    if (idx_i[0]) word_o = ~word_o;
  end
endmodule

// File: rtl/lsv_phase_timer.sv
module lsv_phase_timer #(
  parameter int LIMIT = 4096,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   cnt_q <= '0;
    else if (clr_i)                                cnt_q <= '0;
    else if (en_i && (cnt_q != CW'(LIMIT)))        cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));

  // R8
  timer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(LIMIT));
endmodule

// File: rtl/lsv_rate_validator.sv
module lsv_rate_validator
  import lsv_pkg::*;
#(
  parameter int RW      = 3,
  parameter int DW      = 16,
  parameter int WORDS   = 32,
  parameter int TIMEOUT = 4096,
  localparam int IW     = $clog2(WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [RW-1:0] max_rate_i,
  output logic          wr_req_o,
  input  logic          wr_ack_i,
  output logic          wr_valid_o,
  output logic [DW-1:0] wr_data_o,
  output logic          rd_req_o,
  input  logic          rd_ack_i,
  input  logic          rd_valid_i,
  input  logic [DW-1:0] rd_data_i,
  input  logic          crc_err_i,
  output logic [RW-1:0] rate_o,
  output logic          done_o,
  output logic          link_fail_o,
  output logic          busy_o,
  output logic          xfer_en_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  lsv_state_e    state_q, prev_q;
  logic [RW-1:0] rate_q;
  logic [IW-1:0] idx_q;
  logic          bad_q, locked_q, fail_q, done_q;
  logic [DW-1:0] pat_word;
  logic          expired, tmr_en, in_test;

  lsv_pattern_gen #(.DW(DW), .WORDS(WORDS)) u_pat (
    .idx_i  (idx_q),
    .word_o (pat_word)
  );

  assign tmr_en = (state_q == ST_WR_CMD) || (state_q == ST_RD_CMD) || (state_q == ST_RD_DATA);

  lsv_phase_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (state_q != prev_q),
    .en_i      (tmr_en),
    .expired_o (expired)
  );

  assign in_test = (state_q != ST_IDLE) && (state_q != ST_EVAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      prev_q   <= ST_IDLE;
      rate_q   <= '0;
      idx_q    <= '0;
      bad_q    <= 1'b0;
      locked_q <= 1'b0;
      fail_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      prev_q <= state_q;
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          rate_q   <= max_rate_i;
          locked_q <= 1'b0;
          fail_q   <= 1'b0;
          bad_q    <= 1'b0;
          state_q  <= ST_WR_CMD;
        end
        ST_WR_CMD: begin
          if (wr_ack_i) begin
            idx_q   <= '0;
            state_q <= ST_WR_DATA;
          end else if (expired) begin
            bad_q   <= 1'b1;
            state_q <= ST_EVAL;
          end
        end
        ST_WR_DATA: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) begin
            idx_q   <= '0;
            state_q <= ST_RD_CMD;
          end
        end
        ST_RD_CMD: begin
          if (rd_ack_i) begin
            idx_q   <= '0;
            state_q <= ST_RD_DATA;
          end else if (expired) begin
            bad_q   <= 1'b1;
            state_q <= ST_EVAL;
          end
        end
        ST_RD_DATA: begin
          if (rd_valid_i) begin
            if (rd_data_i != pat_word) bad_q <= 1'b1;
            idx_q <= idx_q + 1'b1;
            if (idx_q == LAST_IDX) state_q <= ST_EVAL;
          end else if (expired) begin
            bad_q   <= 1'b1;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (!bad_q) begin
            locked_q <= 1'b1;
            done_q   <= 1'b1;
            state_q  <= ST_IDLE;
          end else if (rate_q == '0) begin
            fail_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            rate_q  <= rate_q - 1'b1;
            bad_q   <= 1'b0;
            state_q <= ST_WR_CMD;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
      if (in_test && crc_err_i) bad_q <= 1'b1;
    end
  end

  assign wr_req_o    = (state_q == ST_WR_CMD);
  assign wr_valid_o  = (state_q == ST_WR_DATA);
  assign wr_data_o   = pat_word;
  assign rd_req_o    = (state_q == ST_RD_CMD);
  assign busy_o      = (state_q != ST_IDLE);
  assign rate_o      = rate_q;
  assign done_o      = done_q;
  assign link_fail_o = fail_q;
  assign xfer_en_o   = locked_q;

  // R4
  req_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_req_o && rd_req_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  xfer_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_en_o |-> !busy_o);

  // R7
  fail_nolock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_fail_o && xfer_en_o));

  // R6
  rate_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> (rate_o <= $past(rate_o)));
endmodule

// File: tb/tb_lsv_rate_validator.sv
module tb_lsv_rate_validator;
  localparam int TMO = 4096;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  max_rate_i = '0;
  logic        wr_req_o, wr_valid_o, rd_req_o;
  logic        wr_ack_i = 1'b0, rd_ack_i = 1'b0, rd_valid_i = 1'b0, crc_err_i = 1'b0;
  logic [15:0] wr_data_o;
  logic [15:0] rd_data_i = '0;
  logic [2:0]  rate_o;
  logic        done_o, link_fail_o, busy_o, xfer_en_o;

  int n_chk = 0, n_fail = 0;

  // target model controls, one bit per rate index
  logic [7:0]  bad_mask = '0, crc_mask = '0, no_ack_mask = '0, no_rd_mask = '0;
  logic [15:0] mem [32];
  int          eng_st = 0, eng_cnt = 0;
  int          att_n = 0;
  int          att_rate [16];
  logic        prev_wr_req = 1'b0;
  int          done_cnt = 0;

  always #2 clk_i = ~clk_i;

  lsv_rate_validator dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .max_rate_i(max_rate_i),
    .wr_req_o(wr_req_o), .wr_ack_i(wr_ack_i), .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o),
    .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i),
    .crc_err_i(crc_err_i), .rate_o(rate_o), .done_o(done_o), .link_fail_o(link_fail_o),
    .busy_o(busy_o), .xfer_en_o(xfer_en_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // target model: acks commands, captures writes, echoes reads
  always @(negedge clk_i) begin
    wr_ack_i   <= 1'b0;
    rd_ack_i   <= 1'b0;
    rd_valid_i <= 1'b0;
    crc_err_i  <= 1'b0;
    if (!rst_ni) eng_st <= 0;
    else case (eng_st)
      0: if (wr_req_o && !no_ack_mask[rate_o]) begin
           wr_ack_i <= 1'b1; eng_st <= 1; eng_cnt <= 0;
         end else if (rd_req_o) begin
           rd_ack_i <= 1'b1; eng_st <= 2; eng_cnt <= 0;
         end
      1: if (wr_valid_o) begin
           mem[eng_cnt] <= wr_data_o;
           if (eng_cnt == 0 && crc_mask[rate_o]) crc_err_i <= 1'b1;
           if (eng_cnt == 31) eng_st <= 0;
           eng_cnt <= eng_cnt + 1;
         end
      2: if (!busy_o || wr_req_o) eng_st <= 0;
         else if (!no_rd_mask[rate_o]) begin
           rd_valid_i <= 1'b1;
           rd_data_i  <= mem[eng_cnt] ^ ((bad_mask[rate_o] && eng_cnt == 31) ? 16'h8000 : 16'h0000);
           if (eng_cnt == 31) eng_st <= 0;
           eng_cnt <= eng_cnt + 1;
         end
      default: eng_st <= 0;
    endcase
  end

  always @(negedge clk_i) begin
    if (wr_req_o && !prev_wr_req && att_n < 16) begin
      att_rate[att_n] = int'(rate_o);
      att_n++;
    end
    prev_wr_req = wr_req_o;
    if (done_o) done_cnt++;
  end

  task automatic run(input logic [2:0] mx, output int cyc);
    att_n = 0; done_cnt = 0; cyc = 0;
    @(negedge clk_i);
    max_rate_i = mx; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R2: busy from the cycle after start
    chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
    while (!done_o && cyc < 40000) begin
      @(negedge clk_i); cyc++;
    end
    // R9: done coincides with busy drop
    chk(done_o && !busy_o, "R9", "done with idle", int'(busy_o), 0);
    @(negedge clk_i);
    chk(!done_o && done_cnt == 1, "R9", "done pulse count", done_cnt, 1);
  endtask

  task automatic chk_seq(input int first, input int n, input string req);
    chk(att_n == n, req, "attempt count", att_n, n);
    for (int i = 0; i < att_n && i < n; i++)
      chk(att_rate[i] == first - i, req, "attempt rate", att_rate[i], first - i);
  endtask

  task automatic t_reset();
    // R1
    chk(!busy_o, "R1", "busy", busy_o, 0);
    chk(!done_o, "R1", "done", done_o, 0);
    chk(!link_fail_o, "R1", "link_fail", link_fail_o, 0);
    chk(!xfer_en_o, "R1", "xfer_en", xfer_en_o, 0);
    chk(!wr_req_o && !rd_req_o && !wr_valid_o, "R1", "requests", int'(wr_req_o | rd_req_o | wr_valid_o), 0);
  endtask

  task automatic t_clean();
    int c;
    logic [15:0] e;
    run(3'd5, c);
    chk_seq(5, 1, "R2");
    chk(xfer_en_o && rate_o == 3'd5, "R5", "locked rate", int'(rate_o), 5);
    for (int k = 0; k < 32; k++) begin
      e = 16'h0001 << ((k >> 1) % 16);
      if (k % 2 == 1) e = ~e;
      chk(mem[k] == e, "R3", "pattern word", int'(mem[k]), int'(e));
    end
  endtask

  task automatic t_mismatch();
    int c;
    bad_mask = 8'b1100_0000;
    run(3'd7, c);
    chk_seq(7, 3, "R6");
    chk(xfer_en_o && rate_o == 3'd5, "R5", "lock after last-word miscompare", int'(rate_o), 5);
    bad_mask = '0;
  endtask

  task automatic t_crc();
    int c;
    crc_mask = 8'b0000_1000;
    run(3'd3, c);
    chk_seq(3, 2, "R5");
    chk(xfer_en_o && rate_o == 3'd2, "R5", "lock after crc", int'(rate_o), 2);
    crc_mask = '0;
  endtask

  task automatic t_all_fail();
    int c;
    bad_mask = 8'hFF;
    run(3'd1, c);
    chk_seq(1, 2, "R7");
    chk(link_fail_o == 1'b1, "R7", "link_fail", link_fail_o, 1);
    chk(!xfer_en_o, "R7", "no lock", xfer_en_o, 0);
    bad_mask = '0;
  endtask

  task automatic t_no_ack();
    int c;
    no_ack_mask = 8'b0001_0000;
    run(3'd4, c);
    chk_seq(4, 2, "R8");
    chk(c >= TMO, "R8", "write ack timeout length", c, TMO);
    chk(xfer_en_o && rate_o == 3'd3, "R8", "lock after ack timeout", int'(rate_o), 3);
    no_ack_mask = '0;
  endtask

  task automatic t_no_rd();
    int c;
    no_rd_mask = 8'b0000_0100;
    run(3'd2, c);
    chk_seq(2, 2, "R8");
    chk(c >= TMO, "R8", "read data timeout length", c, TMO);
    chk(xfer_en_o && rate_o == 3'd1, "R8", "lock after read timeout", int'(rate_o), 1);
    no_rd_mask = '0;
  endtask

  task automatic t_busy_start();
    int cyc = 0;
    att_n = 0; done_cnt = 0;
    @(negedge clk_i);
    max_rate_i = 3'd6; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    // R10: a new start clears the lock
    chk(!xfer_en_o, "R10", "lock cleared on start", xfer_en_o, 0);
    repeat (10) @(negedge clk_i);
    max_rate_i = 3'd1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    while (!done_o && cyc < 40000) begin
      @(negedge clk_i); cyc++;
      if (busy_o) chk(!xfer_en_o, "R10", "xfer blocked while busy", xfer_en_o, 0);
    end
    @(negedge clk_i);
    chk_seq(6, 1, "R2");
    chk(xfer_en_o && rate_o == 3'd6, "R2", "start ignored while busy", int'(rate_o), 6);
    chk(!busy_o, "R2", "no restart after busy start", busy_o, 0);
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_clean();
    t_mismatch();
    t_crc();
    t_all_fail();
    t_no_ack();
    t_no_rd();
    t_busy_start();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule